// File: doc/BRIEF.md
# Command Word Filter for a Received Byte Stream

This block sits behind a packet receive path that delivers one byte per clock with a valid flag. It watches the stream for two fixed eight-byte control words. The erase word precedes a file transfer and the transfer-complete word follows it, with payload packets of 1024 bytes in between. Every byte that is not part of a recognised control word goes out unchanged on a byte/valid output. The bytes of a recognised word are removed from the stream and replaced by a single-cycle side-band pulse: read-address-clear for the erase word and store-done for the transfer-complete word.

All bytes pass through an eight-stage delay line that shifts on every clock, including empty slots, so the data latency is fixed. A scan state machine counts consecutive valid bytes. Its states are ST_FILL, where fewer than seven consecutive valid bytes are held, ST_ARMED, where at least seven are held and the next valid byte may complete a word, and ST_HIT, the single cycle after a match.

Its transitions are:
- ST_FILL goes to ST_ARMED when the seventh consecutive valid byte arrives. It stays in ST_FILL otherwise, and its count returns to zero on any cycle without a valid byte.
- ST_ARMED goes to ST_HIT when a valid byte completes a word. It goes back to ST_FILL on a cycle without a valid byte, and stays in ST_ARMED on any other valid byte.
- ST_HIT always goes to ST_FILL, with a count of one if a valid byte arrives in that cycle and zero otherwise.

On a match, the delay line drops the eight bytes it holds.

Top module: `bytecmd_filter`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is sampled high, input bytes are not taken. In the cycle after a reset edge, `m_valid`, `clr_rdaddr` and `store_done` are low.
- R2: A valid input byte that is not part of a recognised word appears on `m_byte` with `m_valid` high exactly 7 rising edges after the edge that sampled it. Payload bytes keep their order. A cycle with `s_valid` low produces a cycle with `m_valid` low 7 edges later, and `m_byte` has meaning only when `m_valid` is high.
- R3: Eight consecutive valid bytes D5 D5 D5 D5 FC FC FC FC form the erase word (0xD5D5D5D5FCFCFCFC sent most significant byte first). Receiving it raises `clr_rdaddr` for exactly the one cycle that follows the edge sampling its eighth byte.
- R4: Eight consecutive valid bytes A5 A5 A5 A5 BC BC BC BC form the transfer-complete word (0xA5A5A5A5BCBCBCBC sent most significant byte first). Receiving it raises `store_done` for exactly the one cycle that follows the edge sampling its eighth byte.
- R5: No byte of a recognised word ever appears on the data output. Payload bytes directly before and after such a word, with no idle cycle between them and the word, are forwarded.
- R6: A word counts only if its eight bytes arrive on consecutive cycles. A cycle with `s_valid` low inside the sequence prevents the match, and those bytes are forwarded as data.
- R7: Extra bytes that look like the start of a word, placed in front of a real word (for example a fifth D5 before the erase word), do not prevent the match. Those extra bytes are forwarded as data.
- R8: Words sent back to back with no gap are each recognised. Each match needs eight new bytes received after the previous match.
- R9: Each pulse lasts one cycle, and `clr_rdaddr` and `store_done` are never high in the same cycle.
- R10: A reset that arrives while bytes are held in the delay line discards them. A partly received word is forgotten, so its remaining bytes sent after the reset produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_byte | input | DATA_W | Incoming stream byte |
| s_valid | input | 1 | Incoming byte is valid this cycle |
| m_byte | output | DATA_W | Forwarded payload byte |
| m_valid | output | 1 | Forwarded byte is valid this cycle |
| clr_rdaddr | output | 1 | One-cycle pulse after an erase word |
| store_done | output | 1 | One-cycle pulse after a transfer-complete word |

## Verification
The hardest situation to reach from the ports is a real word arriving directly behind payload bytes that already look like part of a word. In that case the state machine sits in ST_ARMED with a near-miss window and has to match on exactly the right byte. The same applies to a reset landing while seven bytes of a word are already in the delay line. Random payload is drawn with a strong bias towards the four bytes used in the two words, so that partial and overlapping prefixes occur often. Directed sequences add the remaining cases: leading extra prefix bytes, a one-cycle gap inside a word, back-to-back words, and a reset after the seventh byte. A bench model based on a window of the last eight inputs predicts every output cycle.

// File: rtl/bytecmd_filter_pkg.sv
package bytecmd_filter_pkg;

    // Number of recognised control words and their index in the match vector.
    localparam int NUM_CMDS  = 2;
    localparam int CMD_ERASE = 0;
    localparam int CMD_DONE  = 1;

    // Scan state machine.
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIT   = 2'd2
    } scan_state_t;

endpackage

// File: rtl/bytecmd_delay.sv
// Fixed-latency delay line: shifts every clock, with a valid bit per stage.
// Purge clears every valid bit, including the one being loaded.
module bytecmd_delay #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [DATA_W-1:0]                in_data,
    input  logic                             in_valid,
    input  logic                             purge,
    output logic [DEPTH-2:0][DATA_W-1:0]     hist_data,
    output logic [DATA_W-1:0]                out_data,
    output logic                             out_valid
);

    logic [DEPTH-1:0][DATA_W-1:0] tap_data;
    logic [DEPTH-1:0]             tap_vld;

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_data <= '0;
            tap_vld  <= '0;
        end else begin
            tap_data <= {tap_data[DEPTH-2:0], in_data};
            tap_vld  <= {tap_vld[DEPTH-2:0], in_valid} & {DEPTH{~purge}};
        end
    end

    assign hist_data = tap_data[DEPTH-2:0];
    assign out_data  = tap_data[DEPTH-1];
    assign out_valid = tap_vld[DEPTH-1];

endmodule

// File: rtl/bytecmd_match.sv
// Compares the newest byte together with the held history against each
// control word. hist[0] is the most recent held byte, so the oldest byte
// lands in the most significant position of the window.
module bytecmd_match #(
    parameter int DATA_W     = 8,
    parameter int WORD_BYTES = 8,
    parameter int NUM_CMDS   = 2,
    parameter logic [NUM_CMDS*DATA_W*WORD_BYTES-1:0] CMD_TABLE = '0
) (
    input  logic [WORD_BYTES-2:0][DATA_W-1:0] hist,
    input  logic [DATA_W-1:0]                 newest,
    output logic [NUM_CMDS-1:0]               hit
);

    localparam int WORD_W = DATA_W * WORD_BYTES;

    logic [WORD_W-1:0] window;

    assign window = {hist, newest};

    for (genvar c = 0; c < NUM_CMDS; c++) begin : g_cmp
        assign hit[c] = (window == CMD_TABLE[c*WORD_W +: WORD_W]);
    end

endmodule

// File: rtl/bytecmd_filter.sv
module bytecmd_filter
    import bytecmd_filter_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int WORD_BYTES = 8,
    parameter logic [DATA_W*WORD_BYTES-1:0] ERASE_WORD = 64'hD5D5_D5D5_FCFC_FCFC,
    parameter logic [DATA_W*WORD_BYTES-1:0] DONE_WORD  = 64'hA5A5_A5A5_BCBC_BCBC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_byte,
    input  logic              s_valid,
    output logic [DATA_W-1:0] m_byte,
    output logic              m_valid,
    output logic              clr_rdaddr,
    output logic              store_done
);

    localparam int WORD_W = DATA_W * WORD_BYTES;
    localparam int RUN_W  = $clog2(WORD_BYTES);
    localparam logic [RUN_W-1:0] RUN_ARM = RUN_W'(WORD_BYTES - 1);
    localparam logic [RUN_W-1:0] RUN_PRE = RUN_W'(WORD_BYTES - 2);
    localparam logic [NUM_CMDS*WORD_W-1:0] CMD_TABLE = {DONE_WORD, ERASE_WORD};

    scan_state_t                        state, state_nx;
    logic [RUN_W-1:0]                   run, run_nx;
    logic [WORD_BYTES-2:0][DATA_W-1:0]  hist;
    logic [NUM_CMDS-1:0]                hit;
    logic                               fire;
    logic                               clr_q, done_q;

    bytecmd_delay #(
        .DATA_W (DATA_W),
        .DEPTH  (WORD_BYTES)
    ) u_delay (
        .clk       (clk),
        .rst       (rst),
        .in_data   (s_byte),
        .in_valid  (s_valid),
        .purge     (fire),
        .hist_data (hist),
        .out_data  (m_byte),
        .out_valid (m_valid)
    );

    bytecmd_match #(
        .DATA_W     (DATA_W),
        .WORD_BYTES (WORD_BYTES),
        .NUM_CMDS   (NUM_CMDS),
        .CMD_TABLE  (CMD_TABLE)
    ) u_match (
        .hist   (hist),
        .newest (s_byte),
        .hit    (hit)
    );

    // A word completes only when seven consecutive valid bytes are held.
    assign fire = (state == ST_ARMED) && s_valid && (|hit);

    // Next state: run counts consecutive valid bytes sitting in the line.
    always_comb begin
        state_nx = state;
        run_nx   = run;
        unique case (state)
            ST_FILL: begin
                if (!s_valid) begin
                    run_nx = '0;
                end else if (run == RUN_PRE) begin
                    run_nx   = RUN_ARM;
                    state_nx = ST_ARMED;
                end else begin
                    run_nx = run + 1'b1;
                end
            end
            ST_ARMED: begin
                if (!s_valid) begin
                    run_nx   = '0;
                    state_nx = ST_FILL;
                end else if (|hit) begin
                    run_nx   = '0;
                    state_nx = ST_HIT;
                end
            end
            ST_HIT: begin
                state_nx = ST_FILL;
                run_nx   = s_valid ? RUN_W'(1) : '0;
            end
            default: begin
                state_nx = ST_FILL;
                run_nx   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;
            run   <= '0;
        end else begin
            state <= state_nx;
            run   <= run_nx;
        end
    end

    // Side-band pulse outputs.
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            clr_q  <= fire & hit[CMD_ERASE];
            done_q <= fire & hit[CMD_DONE];
        end
    end

    assign clr_rdaddr = clr_q;
    assign store_done = done_q;

    // R9: the two pulses never coincide
    a_r9_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(clr_rdaddr && store_done));

    // R9: each pulse is a single cycle wide
    a_r9_clear_one_cycle: assert property (@(posedge clk) disable iff (rst)
        clr_rdaddr |=> !clr_rdaddr);

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        store_done |=> !store_done);

    // R5: a pulse cycle never carries a word byte on the data output
    a_r5_no_word_leak: assert property (@(posedge clk) disable iff (rst)
        (clr_rdaddr || store_done) |-> !m_valid);

    // R6: a pulse follows a cycle in which a valid byte was taken
    a_r6_pulse_after_valid: assert property (@(posedge clk) disable iff (rst)
        (clr_rdaddr || store_done) |-> $past(s_valid));

    // R8: a match is never followed by another match on the next byte
    a_r8_no_hit_repeat: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HIT) |=> (state != ST_HIT));

    // R1: the cycle after a reset edge is quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!m_valid && !clr_rdaddr && !store_done));

endmodule

// File: tb/bytecmd_filter_bench.sv
module bytecmd_filter_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 20000;
    localparam int WDOG       = 150000;
    localparam logic [63:0] W_ERASE = 64'hD5D5D5D5FCFCFCFC;
    localparam logic [63:0] W_DONE  = 64'hA5A5A5A5BCBCBCBC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] s_byte = 8'h00;
    logic       s_valid = 1'b0;
    logic [7:0] m_byte;
    logic       m_valid;
    logic       clr_rdaddr;
    logic       store_done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bytecmd_filter u_bytecmd_filter (
        .clk        (clk),
        .rst        (rst),
        .s_byte     (s_byte),
        .s_valid    (s_valid),
        .m_byte     (m_byte),
        .m_valid    (m_valid),
        .clr_rdaddr (clr_rdaddr),
        .store_done (store_done)
    );

    // Per-cycle input history and model expectations.
    logic       hv    [MAXC];
    logic [7:0] hd    [MAXC];
    logic       disc  [MAXC];
    logic       pclr  [MAXC];
    logic       pdone [MAXC];

    int    cyc   = 0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    function automatic logic [63:0] window_word(input int n);
        logic [63:0] w = '0;
        for (int k = 7; k >= 0; k--) w = {w[55:0], hd[n-k]};
        return w;
    endfunction

    function automatic bit window_usable(input int n);
        for (int k = 0; k < 8; k++) begin
            if (!hv[n-k] || disc[n-k]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [7:0] pick_byte();
        int unsigned r = $urandom_range(0, 9);
        case (r)
            0: return 8'hD5;
            1: return 8'hFC;
            2: return 8'hA5;
            3: return 8'hBC;
            default: return 8'($urandom);
        endcase
    endfunction

    // Compare the outputs seen after edge m with the model.
    task automatic check_outputs(input int m);
        logic       ev;
        logic [7:0] ed;
        if (m < 0) return;
        ev = (m >= 7) ? (hv[m-7] && !disc[m-7]) : 1'b0;
        ed = (m >= 7) ? hd[m-7] : 8'h00;
        n_chk++;
        if (m_valid !== ev || (ev && m_byte !== ed)) begin
            n_bad++;
            $display("FAIL %s data at cycle %0d: got v=%0b d=%02h, expected v=%0b d=%02h",
                     tag, m, m_valid, m_byte, ev, ed);
        end
        n_chk++;
        if (clr_rdaddr !== pclr[m] || store_done !== pdone[m]) begin
            n_bad++;
            $display("FAIL %s pulses at cycle %0d: got clr=%0b done=%0b, expected clr=%0b done=%0b",
                     tag, m, clr_rdaddr, store_done, pclr[m], pdone[m]);
        end
    endtask

    // One clock: check the previous edge's result, then drive this cycle.
    task automatic step(input logic v, input logic [7:0] d, input logic r);
        logic [63:0] w;
        @(negedge clk);
        check_outputs(cyc - 1);
        rst     = r;
        s_valid = v;
        s_byte  = d;
        hv[cyc]    = v && !r;
        hd[cyc]    = d;
        disc[cyc]  = 1'b0;
        pclr[cyc]  = 1'b0;
        pdone[cyc] = 1'b0;
        if (r) begin
            for (int k = 1; k < 8; k++) if (cyc - k >= 0) disc[cyc-k] = 1'b1;
        end else if (cyc >= 7 && window_usable(cyc)) begin
            w = window_word(cyc);
            if (w == W_ERASE || w == W_DONE) begin
                pclr[cyc]  = (w == W_ERASE);
                pdone[cyc] = (w == W_DONE);
                for (int k = 0; k < 8; k++) disc[cyc-k] = 1'b1;
            end
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b0);
    endtask

    task automatic send_word(input logic [63:0] w);
        for (int k = 0; k < 8; k++) step(1'b1, w[63-8*k -: 8], 1'b0);
    endtask

    task automatic send_payload(input int len, input int gap_pct);
        for (int i = 0; i < len; i++) begin
            if ($urandom_range(0, 99) < gap_pct) step(1'b0, 8'($urandom), 1'b0);
            step(1'b1, pick_byte(), 1'b0);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: got no end after %0d cycles, expected end", WDOG);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1: reset with valid word bytes offered; nothing must be taken
        tag = "R1";
        repeat (4) step(1'b1, 8'hD5, 1'b1);
        idle(10);

        // R2: random payload packets with and without idle gaps
        tag = "R2";
        for (int p = 0; p < 6; p++) begin
            send_payload($urandom_range(1, 64), (p % 2) * 20);
            idle($urandom_range(0, 5));
        end
        idle(10);

        // R3: isolated erase word
        tag = "R3";
        send_word(W_ERASE);
        idle(12);

        // R4: isolated transfer-complete word
        tag = "R4";
        send_word(W_DONE);
        idle(12);

        // R5: words glued to payload on both sides
        tag = "R5";
        send_payload(20, 0);
        send_word(W_ERASE);
        send_payload(20, 0);
        send_word(W_DONE);
        send_payload(10, 0);
        idle(12);

        // R6: gap inside a word, and a word with a wrong final byte
        tag = "R6";
        for (int k = 0; k < 4; k++) step(1'b1, W_ERASE[63-8*k -: 8], 1'b0);
        step(1'b0, 8'hFC, 1'b0);
        for (int k = 4; k < 8; k++) step(1'b1, W_ERASE[63-8*k -: 8], 1'b0);
        idle(10);
        for (int k = 0; k < 7; k++) step(1'b1, W_DONE[63-8*k -: 8], 1'b0);
        step(1'b1, 8'hBD, 1'b0);
        idle(12);

        // R7: extra prefix bytes before real words
        tag = "R7";
        step(1'b1, 8'hD5, 1'b0);
        step(1'b1, 8'hD5, 1'b0);
        send_word(W_ERASE);
        step(1'b1, 8'hA5, 1'b0);
        send_word(W_DONE);
        for (int k = 0; k < 6; k++) step(1'b1, W_DONE[63-8*k -: 8], 1'b0);
        send_word(W_DONE);
        idle(12);

        // R8: back-to-back words with no gap
        tag = "R8";
        send_word(W_ERASE);
        send_word(W_ERASE);
        send_word(W_DONE);
        send_word(W_DONE);
        idle(12);

        // R9: alternating words, pulses one cycle and exclusive
        tag = "R9";
        for (int i = 0; i < 3; i++) begin
            send_word(W_DONE);
            send_word(W_ERASE);
        end
        idle(12);

        // R10: reset after the seventh byte of a word, then the last byte
        tag = "R10";
        send_payload(5, 0);
        for (int k = 0; k < 7; k++) step(1'b1, W_ERASE[63-8*k -: 8], 1'b0);
        step(1'b1, 8'hFC, 1'b1);
        step(1'b1, 8'hFC, 1'b0);
        idle(12);
        send_payload(5, 0);
        step(1'b0, 8'h00, 1'b1);
        idle(12);

        // R2: one full-size packet framed by the two words, with gaps
        tag = "R2";
        send_word(W_ERASE);
        send_payload(1024, 10);
        send_word(W_DONE);
        idle(12);

        finished = 1'b1;
        finish_run();
    end

endmodule